// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns one decoded floating-point data-processing operation into the series of register numbers that a short-vector execution walks through. The register file holds 32 single-precision entries or 16 double-precision entries. Each precision splits its file into four banks: eight registers per bank for single precision and four for double precision. The caller supplies the starting destination, first-source and second-source numbers, the precision, whether the operation reads one source or two, a force-scalar flag, and the current vector length and stride. The block then emits one register triple per step on a valid/ready channel and marks the final step.

The destination's bank decides the mode. A destination in bank 0 gives a scalar operation. Otherwise the operation runs as a vector. If the second source is then in bank 0, that source stays fixed and the operation is mixed scalar/vector. Indices always wrap inside the bank they started in.

A one-source operation with a fixed source computes its result only once. Every later step is flagged as write-only, so the consumer stores the first result again into the next destination. Register-file access and arithmetic belong to the consumer.

Top module: `vseq_index_gen`

## Requirements
- R1: After reset, `op_ready` is 1 and `stp_valid` is 0.
- R2: An operation is taken only on a cycle where `op_valid` and `op_ready` are both 1. The first step is presented with `stp_valid`=1 on the next cycle. While a step is pending, `op_ready` is 0 and any `op_valid` is ignored.
- R3: While `stp_valid`=1 and `stp_ready`=0, every step output holds its value.
- R4: Bank 0 is indices 0..7 in single precision and 0..3 in double precision. A destination in bank 0 gives exactly one step, with `stp_last`=1 and the start indices unchanged.
- R5: The advance step is stride+1 in single precision and (stride>>1)+1 in double precision.
- R6: An index advances as (r AND NOT low) OR ((r+step) AND low). Here low is 7 for single precision and 3 for double precision, so the index stays in its bank.
- R7: A vector operation gives length+1 steps, and only the final step has `stp_last`=1. A length of 0 gives one step.
- R8: In a two-source vector operation, the first source advances with the destination. The second source advances too, unless it starts in bank 0, in which case it stays fixed.
- R9: With `op_force_scalar`=1, exactly one step is produced, whatever the length or the banks.
- R10: In a one-source operation, `stp_src1` keeps its start value. If the source starts in bank 0, every step after the first has `stp_write_only`=1 and `stp_src2` unchanged. Otherwise the source advances and `stp_write_only` stays 0. The first step always has `stp_write_only`=0.
- R11: In double precision, bit 4 of every input index is ignored, and bit 4 of every output index is 0.
- R12: On the cycle after the last step is taken, `stp_valid` is 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | New operation offered |
| op_ready | output | 1 | Sequencer idle, operation can be taken |
| op_dst | input | 5 | Start destination index |
| op_src1 | input | 5 | Start first-source index |
| op_src2 | input | 5 | Start second-source index (the operand of one-source operations) |
| op_dbl | input | 1 | 1 = double precision |
| op_single_src | input | 1 | 1 = operation reads one source |
| op_force_scalar | input | 1 | 1 = run as a single step |
| op_len | input | 3 | Vector length minus one |
| op_stride | input | 2 | Stride field |
| stp_valid | output | 1 | Step triple presented |
| stp_ready | input | 1 | Consumer takes the step |
| stp_dst | output | 5 | Destination index of this step |
| stp_src1 | output | 5 | First-source index of this step |
| stp_src2 | output | 5 | Second-source index of this step |
| stp_last | output | 1 | Final step of the operation |
| stp_write_only | output | 1 | Store the earlier result again, read nothing |

## Verification
A corrupted remaining-step count shows up as a `stp_last` that is early, late or missing on the same operation. A wrong latched step or precision bit first appears on the second step of a vector as a wrong destination index. A bad bank or fixed-source decision shows as a source that advances when it should hold, or the reverse, also from the second step. Wrap errors appear only at the step that crosses the top of a bank, so the stimulus mixes strides and start positions near bank ends.

// File: rtl/vseq_pkg.sv
// Shared types for the short-vector index sequencer.
package vseq_pkg;
    // How an accepted operation will be walked.
    typedef enum logic [1:0] {
        VK_SCALAR = 2'd0,
        VK_MIXED  = 2'd1,
        VK_VECTOR = 2'd2
    } vseq_kind_e;
endpackage

// File: rtl/vseq_plan.sv
// vseq_plan: combinational decode of an offered operation.
// Masks indices for double precision, computes the advance step and
// classifies the operation as scalar, mixed or full vector.
// Assumes IDX_W > SP_LO_BITS > DP_LO_BITS.
module vseq_plan
    import vseq_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int LEN_W      = 3,
    parameter int STRIDE_W   = 2,
    parameter int SP_LO_BITS = 3,
    parameter int DP_LO_BITS = 2
) (
    input  logic [IDX_W-1:0]    dst_i,
    input  logic [IDX_W-1:0]    src1_i,
    input  logic [IDX_W-1:0]    src2_i,
    input  logic                dbl_i,
    input  logic                force_scalar_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [STRIDE_W-1:0] stride_i,
    output logic [IDX_W-1:0]    dst_o,
    output logic [IDX_W-1:0]    src1_o,
    output logic [IDX_W-1:0]    src2_o,
    output logic [STRIDE_W:0]   step_o,
    output logic                hold_src2_o,
    output logic [LEN_W-1:0]    runs_m1_o
);
    localparam int STEP_W = STRIDE_W + 1;
    localparam logic [IDX_W-1:0] DP_KEEP = IDX_W'((1 << (IDX_W - 1)) - 1);
    localparam logic [IDX_W-1:0] SP_LOW  = IDX_W'((1 << SP_LO_BITS) - 1);
    localparam logic [IDX_W-1:0] DP_LOW  = IDX_W'((1 << DP_LO_BITS) - 1);
    localparam logic [IDX_W-1:0] SP_BANK = ~SP_LOW;
    localparam logic [IDX_W-1:0] DP_BANK = DP_KEEP & ~DP_LOW;

    logic [IDX_W-1:0] bank;
    logic             dst_b0;
    logic             src2_b0;
    vseq_kind_e       kind;

    // Purpose: clear the unused top bit of double-precision indices.
    always_comb begin
        dst_o  = dbl_i ? (dst_i  & DP_KEEP) : dst_i;
        src1_o = dbl_i ? (src1_i & DP_KEEP) : src1_i;
        src2_o = dbl_i ? (src2_i & DP_KEEP) : src2_i;
    end

    // Purpose: advance distance per step for the chosen precision.
    always_comb begin
        if (dbl_i) step_o = STEP_W'(stride_i >> 1) + STEP_W'(1);
        else       step_o = STEP_W'(stride_i) + STEP_W'(1);
    end

    // Purpose: classify the operation from the banks of destination and second source.
    always_comb begin
        bank    = dbl_i ? DP_BANK : SP_BANK;
        dst_b0  = (dst_o & bank) == '0;
        src2_b0 = (src2_o & bank) == '0;
        if (force_scalar_i || len_i == '0 || dst_b0) kind = VK_SCALAR;
        else if (src2_b0)                              kind = VK_MIXED;
        else                                           kind = VK_VECTOR;
        hold_src2_o = (kind == VK_MIXED);
        runs_m1_o   = (kind == VK_SCALAR) ? '0 : len_i;
    end
endmodule

// File: rtl/vseq_wrap_add.sv
// vseq_wrap_add: adds a step to a register index, keeping the bank bits.
// The low field is 3 bits wide for single precision and 2 bits for
// double precision. Assumes STEP_W < IDX_W.
module vseq_wrap_add #(
    parameter int IDX_W      = 5,
    parameter int STEP_W     = 3,
    parameter int SP_LO_BITS = 3,
    parameter int DP_LO_BITS = 2
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              dbl_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [IDX_W-1:0] SP_LOW = IDX_W'((1 << SP_LO_BITS) - 1);
    localparam logic [IDX_W-1:0] DP_LOW = IDX_W'((1 << DP_LO_BITS) - 1);

    logic [IDX_W-1:0] low;
    logic [IDX_W-1:0] sum;

    // Purpose: wrap the incremented index within its bank.
    always_comb begin
        low   = dbl_i ? DP_LOW : SP_LOW;
        sum   = idx_i + {{(IDX_W - STEP_W){1'b0}}, step_i};
        idx_o = (idx_i & ~low) | (sum & low);
    end
endmodule

// File: rtl/vseq_index_gen.sv
// vseq_index_gen: short-vector register index sequencer (top).
// Takes one operation while idle, then presents one register triple per
// step. A step is held until the consumer takes it. Slot 0 is the
// destination, slot 1 the first source, slot 2 the second source.
// Assumes the consumer handles register access and arithmetic.
module vseq_index_gen
    import vseq_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int LEN_W      = 3,
    parameter int STRIDE_W   = 2,
    parameter int SP_LO_BITS = 3,
    parameter int DP_LO_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic [IDX_W-1:0]    op_dst,
    input  logic [IDX_W-1:0]    op_src1,
    input  logic [IDX_W-1:0]    op_src2,
    input  logic                op_dbl,
    input  logic                op_single_src,
    input  logic                op_force_scalar,
    input  logic [LEN_W-1:0]    op_len,
    input  logic [STRIDE_W-1:0] op_stride,
    output logic                stp_valid,
    input  logic                stp_ready,
    output logic [IDX_W-1:0]    stp_dst,
    output logic [IDX_W-1:0]    stp_src1,
    output logic [IDX_W-1:0]    stp_src2,
    output logic                stp_last,
    output logic                stp_write_only
);
    localparam int STEP_W = STRIDE_W + 1;
    localparam int SLOTS  = 3;

    // Decoded view of the offered operation.
    logic [IDX_W-1:0]  pl_dst, pl_src1, pl_src2;
    logic [STEP_W-1:0] pl_step;
    logic              pl_hold;
    logic [LEN_W-1:0]  pl_runs_m1;

    // Sequencing state.
    logic                        busy_q;
    logic [SLOTS-1:0][IDX_W-1:0] idx_q;
    logic [SLOTS-1:0][IDX_W-1:0] idx_adv;
    logic [SLOTS-1:0]            slot_keep;
    logic [LEN_W-1:0]            remain_q;
    logic [STEP_W-1:0]           step_q;
    logic                        dbl_q, one_q, hold_q, reuse_q;
    logic                        accept, fire;

    vseq_plan #(
        .IDX_W(IDX_W), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W),
        .SP_LO_BITS(SP_LO_BITS), .DP_LO_BITS(DP_LO_BITS)
    ) u_plan (
        .dst_i(op_dst), .src1_i(op_src1), .src2_i(op_src2),
        .dbl_i(op_dbl), .force_scalar_i(op_force_scalar),
        .len_i(op_len), .stride_i(op_stride),
        .dst_o(pl_dst), .src1_o(pl_src1), .src2_o(pl_src2),
        .step_o(pl_step), .hold_src2_o(pl_hold), .runs_m1_o(pl_runs_m1)
    );

    // One wrap adder per index slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        vseq_wrap_add #(
            .IDX_W(IDX_W), .STEP_W(STEP_W),
            .SP_LO_BITS(SP_LO_BITS), .DP_LO_BITS(DP_LO_BITS)
        ) u_adv (
            .idx_i(idx_q[g]), .step_i(step_q), .dbl_i(dbl_q), .idx_o(idx_adv[g])
        );
    end

    // Purpose: handshake qualifiers and which slots stay put between steps.
    always_comb begin
        accept       = op_valid && !busy_q;
        fire         = busy_q && stp_ready;
        slot_keep[0] = 1'b0;
        slot_keep[1] = one_q;
        slot_keep[2] = hold_q;
    end

    // Purpose: load a new operation, or advance or retire on each taken step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            idx_q    <= '0;
            remain_q <= '0;
            step_q   <= '0;
            dbl_q    <= 1'b0;
            one_q    <= 1'b0;
            hold_q   <= 1'b0;
            reuse_q  <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            idx_q[0] <= pl_dst;
            idx_q[1] <= pl_src1;
            idx_q[2] <= pl_src2;
            remain_q <= pl_runs_m1;
            step_q   <= pl_step;
            dbl_q    <= op_dbl;
            one_q    <= op_single_src;
            hold_q   <= pl_hold;
            reuse_q  <= 1'b0;
        end else if (fire) begin
            if (remain_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                remain_q <= remain_q - LEN_W'(1);
                reuse_q  <= one_q && hold_q;
                for (int s = 0; s < SLOTS; s++) begin
                    if (!slot_keep[s]) idx_q[s] <= idx_adv[s];
                end
            end
        end
    end

    // Purpose: drive the port view of the current state.
    always_comb begin
        op_ready       = !busy_q;
        stp_valid      = busy_q;
        stp_dst        = idx_q[0];
        stp_src1       = idx_q[1];
        stp_src2       = idx_q[2];
        stp_last       = (remain_q == '0);
        stp_write_only = reuse_q;
    end
endmodule

// File: rtl/vseq_index_gen_chk.sv
// vseq_index_gen_chk: port-level temporal checks, bound into the top.
module vseq_index_gen_chk #(
    parameter int IDX_W      = 5,
    parameter int SP_LO_BITS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_ready,
    input logic             stp_valid,
    input logic             stp_ready,
    input logic             stp_last,
    input logic             stp_write_only,
    input logic [IDX_W-1:0] stp_dst,
    input logic [IDX_W-1:0] stp_src2
);
    // R2: a taken operation shows its first step next cycle, never write-only.
    a_r2_first_step: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready |=> stp_valid && !stp_write_only);

    // R3: a stalled step keeps its contents.
    a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid && !stp_ready |=> stp_valid && $stable(stp_dst)
            && $stable(stp_src2) && $stable(stp_last) && $stable(stp_write_only));

    // R6: advancing never leaves the starting bank.
    a_r6_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid && stp_ready && !stp_last |=>
            stp_dst[IDX_W-1:SP_LO_BITS] == $past(stp_dst[IDX_W-1:SP_LO_BITS]));

    // R10: write-only steps follow each other with a fixed source.
    a_r10_reuse_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid && stp_ready && !stp_last && stp_write_only |=>
            stp_write_only && $stable(stp_src2));

    // R12: taking the last step returns the block to idle.
    a_r12_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid && stp_ready && stp_last |=> !stp_valid && op_ready);
endmodule

bind vseq_index_gen vseq_index_gen_chk #(.IDX_W(IDX_W), .SP_LO_BITS(SP_LO_BITS)) u_chk (.*);

// File: tb/vseq_index_gen_test.sv
module vseq_index_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [4:0] op_dst = '0, op_src1 = '0, op_src2 = '0;
    logic       op_dbl = 1'b0, op_single_src = 1'b0, op_force_scalar = 1'b0;
    logic [2:0] op_len = '0;
    logic [1:0] op_stride = '0;
    logic       stp_valid;
    logic       stp_ready = 1'b0;
    logic [4:0] stp_dst, stp_src1, stp_src2;
    logic       stp_last, stp_write_only;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    vseq_index_gen uut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [4:0] wrap_step(logic [4:0] r, int st, logic [4:0] lo);
        logic [4:0] s;
        s = r + 5'(st);
        return (r & ~lo) | (s & lo);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Apply one operation and follow it to the end, stalling and offering noise at random.
    task automatic run_op(logic [4:0] d, logic [4:0] s1, logic [4:0] s2, bit dbl, bit one,
                          bit fs, logic [2:0] len, logic [1:0] str, string tag,
                          int stall, bit noise);
        logic [4:0] lo, bk, ed, e1, e2;
        int st, n, k;
        bit vec, fix, rdy;
        lo = dbl ? 5'd3 : 5'd7;
        bk = dbl ? 5'd12 : 5'd24;
        ed = dbl ? (d & 5'h0f) : d;
        e1 = dbl ? (s1 & 5'h0f) : s1;
        e2 = dbl ? (s2 & 5'h0f) : s2;
        st = dbl ? (int'(str) >> 1) + 1 : int'(str) + 1;
        vec = !fs && len != 0 && (ed & bk) != 0;
        n   = vec ? int'(len) + 1 : 1;
        fix = (e2 & bk) == 0;

        @(negedge clk);
        check(op_ready == 1'b1, "R2", "op_ready before offer", op_ready, 1);
        op_dst = d; op_src1 = s1; op_src2 = s2; op_dbl = dbl; op_single_src = one;
        op_force_scalar = fs; op_len = len; op_stride = str; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        k = 0;
        while (k < n) begin
            rdy = ($urandom % 100) >= stall;
            stp_ready = rdy;
            if (noise && ($urandom % 2 == 1)) begin
                op_valid = 1'b1;
                op_dst = 5'($urandom); op_src2 = 5'($urandom); op_len = 3'($urandom);
            end else begin
                op_valid = 1'b0;
            end
            check(stp_valid == 1'b1, tag, "stp_valid", stp_valid, 1);
            check(op_ready == 1'b0, "R2", "op_ready while busy", op_ready, 0);
            check(stp_dst == ed, tag, "stp_dst", stp_dst, ed);
            check(stp_src1 == e1, tag, "stp_src1", stp_src1, e1);
            check(stp_src2 == e2, tag, "stp_src2", stp_src2, e2);
            check(stp_last == (k == n - 1), tag, "stp_last", stp_last, k == n - 1);
            check(stp_write_only == (one && fix && k > 0), tag, "stp_write_only",
                  stp_write_only, one && fix && k > 0);
            @(negedge clk);
            op_valid = 1'b0;
            if (rdy) begin
                ed = wrap_step(ed, st, lo);
                if (!one) e1 = wrap_step(e1, st, lo);
                if (!fix) e2 = wrap_step(e2, st, lo);
                k++;
            end
        end
        stp_ready = 1'b0;
        check(stp_valid == 1'b0, "R12", "stp_valid after last", stp_valid, 0);
        check(op_ready == 1'b1, "R12", "op_ready after last", op_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready == 1'b1, "R1", "op_ready after reset", op_ready, 1);
        check(stp_valid == 1'b0, "R1", "stp_valid after reset", stp_valid, 0);

        run_op(5'd5, 5'd9, 5'd17, 0, 0, 0, 3'd5, 2'd0, "R4", 0, 0);    // scalar destination
        run_op(5'd8, 5'd16, 5'd24, 0, 0, 0, 3'd3, 2'd0, "R7", 30, 0);  // plain vector
        run_op(5'd14, 5'd22, 5'd31, 0, 0, 0, 3'd3, 2'd1, "R6", 0, 0);  // wrap at bank top
        run_op(5'd12, 5'd20, 5'd3, 0, 0, 0, 3'd4, 2'd3, "R8", 20, 0);  // mixed fixed source
        run_op(5'd12, 5'd20, 5'd28, 0, 0, 1, 3'd7, 2'd0, "R9", 0, 0);  // force scalar
        run_op(5'd20, 5'd25, 5'd1, 1, 0, 0, 3'd2, 2'd3, "R11", 0, 0);  // double, bit4 dropped
        run_op(5'd6, 5'd15, 5'd10, 1, 0, 0, 3'd3, 2'd2, "R5", 0, 0);   // double step 2
        run_op(5'd9, 5'd30, 5'd2, 0, 1, 0, 3'd4, 2'd0, "R10", 40, 1);  // reuse of first result
        run_op(5'd9, 5'd30, 5'd17, 0, 1, 0, 3'd2, 2'd1, "R10", 0, 0);  // one-source vector
        run_op(5'd16, 5'd8, 5'd24, 0, 0, 0, 3'd0, 2'd2, "R7", 0, 0);   // length zero
        run_op(5'd10, 5'd11, 5'd12, 0, 0, 0, 3'd2, 2'd0, "R3", 80, 1); // long stalls

        for (int i = 0; i < 150; i++) begin
            run_op(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 8) == 0, 3'($urandom), 2'($urandom), "R8", 35, 1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule